// File: doc/BRIEF.md
# Phase-Frequency Detector with Fast-Acquire Pump Scaling

This block is the digital half of a frequency-synthesizer loop. It takes two single-cycle strobes from the system clock domain. One marks each edge of the divided reference. The other marks each edge of the divided local oscillator. From these it produces pump-up and pump-down pulses whose length equals the phase gap between the two edges. The analog charge pump, the loop filter and the oscillator sit outside the block.

Alongside the detector, a fast-acquire controller picks the charge-pump current multiple for the next correction pulse. It measures the width of each finished pulse in units of an interval T. T is a programmable number of reference periods, and both the width and T are counted in system-clock cycles. A wide phase error therefore raises the pump current for the next pulse. The rule never drops the current below the nominal setting. With the controller enabled, the current is at least twice the unit current.

All pins are plain control and status wires. The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure. Every strobe is taken in the cycle it is presented.

Top module: `pfd_fastacq`

## Requirements
- R1: While `rst_n` is low, and after reset, `pump_up` and `pump_down` are 0 and `pump_scale` is 0.
- R2: A `ref_strobe` sampled on a clock edge sets `pump_up` from that edge on. A `lo_strobe` does the same for `pump_down`. Each stays high until the other one has also been set.
- R3: In a cycle where both `pump_up` and `pump_down` are high, both fall at the next edge, so strobes given together produce a one-cycle overlap. Strobes sampled on that clearing edge are ignored.
- R4: The pulse width W is the number of cycles in which exactly one of `pump_up` and `pump_down` is high. It equals the number of cycles by which the leading strobe arrives before the trailing one.
- R5: T is the number of cycles spanned by D consecutive reference periods. D is `acq_div`, and a value of 0 acts as 1. T is re-measured every D reference periods. Until the first span after reset is complete, the quotient used below is 0.
- R6: With `acq_en` = 0, `pump_scale` takes the value of `cp_nominal` at the end of each pulse.
- R7: With `acq_en` = 1, `pump_scale` at the end of each pulse becomes min(7, max(1, `cp_nominal`, floor(W/T))). The pump current multiple is `pump_scale`+1, so the range is 1x to 8x, with a floor of 2x and a cap of 8x.
- R8: `pump_scale` changes only on the edge right after a cycle with both pump outputs high. A change of `cp_nominal` or `acq_en` between pulses leaves it unchanged until the next pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_strobe | input | 1 | One-cycle strobe per divided-reference edge |
| lo_strobe | input | 1 | One-cycle strobe per divided-oscillator edge |
| cp_nominal | input | 3 | Nominal pump code, multiple = code+1 |
| acq_div | input | DIV_W (8) | Reference periods per interval T (0 acts as 1) |
| acq_en | input | 1 | Fast-acquire enable |
| pump_up | output | 1 | Pump-up pulse (reference leads) |
| pump_down | output | 1 | Pump-down pulse (oscillator leads) |
| pump_scale | output | 3 | Pump multiple code for the current pulse, multiple = code+1 |

## Verification
A strobe presented before edge k shows on its pump output after edge k. The overlap cycle follows the trailing strobe by one edge. The clear and the new `pump_scale` both appear one edge after the overlap. The bench drives every input on falling edges and samples on falling edges: it checks the leading output one falling edge after its strobe, the overlap on the next falling edge after the trailing strobe, and the cleared outputs, counted width and scale code on the falling edge after that. T is set up by paired strobes three cycles apart, so every expected quotient is known by hand. A stretch of idle cycles after a change of nominal code confirms that the scale code holds.

// File: rtl/pfdfa_pkg.sv
package pfdfa_pkg;
  localparam int MULT_W = 3;
  localparam int MULT_MAX = (1 << MULT_W) - 1;

  typedef logic [MULT_W-1:0] scale_t;

  function automatic scale_t max3(input scale_t a, input scale_t b, input scale_t c);
    scale_t m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_strobe,
  input  logic lo_strobe,
  output logic pump_up,
  output logic pump_down,
  output logic pulse_end
);
  assign pulse_end = pump_up & pump_down;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pump_up   <= 1'b0;
      pump_down <= 1'b0;
    end else if (pulse_end) begin
      pump_up   <= 1'b0;
      pump_down <= 1'b0;
    end else begin
      if (ref_strobe) pump_up   <= 1'b1;
      if (lo_strobe)  pump_down <= 1'b1;
    end
  end
endmodule

// File: rtl/fa_interval_meter.sv
module fa_interval_meter #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_strobe,
  input  logic [DIV_W-1:0] acq_div,
  output logic [CNT_W-1:0] interval,
  output logic             interval_ok
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] tick_cnt;
  logic [CNT_W-1:0] cyc_cnt;
  logic             started;
  logic             cyc_room;

  assign div_eff  = (acq_div == '0) ? DIV_W'(1) : acq_div;
  assign cyc_room = (cyc_cnt != CNT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt    <= '0;
      cyc_cnt     <= '0;
      started     <= 1'b0;
      interval    <= '0;
      interval_ok <= 1'b0;
    end else if (ref_strobe) begin
      if (!started) begin
        started  <= 1'b1;
        cyc_cnt  <= CNT_W'(1);
        tick_cnt <= '0;
      end else if (tick_cnt >= div_eff - DIV_W'(1)) begin
        interval    <= cyc_cnt;
        interval_ok <= 1'b1;
        cyc_cnt     <= CNT_W'(1);
        tick_cnt    <= '0;
      end else begin
        tick_cnt <= tick_cnt + DIV_W'(1);
        if (cyc_room) cyc_cnt <= cyc_cnt + CNT_W'(1);
      end
    end else if (started && cyc_room) begin
      cyc_cnt <= cyc_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/fa_width_quantizer.sv
module fa_width_quantizer
  import pfdfa_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pump_up,
  input  logic             pump_down,
  input  logic [CNT_W-1:0] interval,
  input  logic             interval_ok,
  output scale_t           quot
);
  localparam int PROD_W = CNT_W + MULT_W;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0]  width_cnt;
  logic [PROD_W-1:0] width_ext;
  logic [PROD_W-1:0] intv_ext;
  logic [MULT_MAX:1] reached;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_cnt <= '0;
    end else if (pump_up && pump_down) begin
      width_cnt <= '0;
    end else if ((pump_up ^ pump_down) && width_cnt != CNT_TOP) begin
      width_cnt <= width_cnt + CNT_W'(1);
    end
  end

  assign width_ext = {{MULT_W{1'b0}}, width_cnt};
  assign intv_ext  = {{MULT_W{1'b0}}, interval};

  for (genvar j = 1; j <= MULT_MAX; j++) begin : g_thr
    localparam logic [PROD_W-1:0] STEP = PROD_W'(j);
    logic [PROD_W-1:0] thr;
    assign thr        = STEP * intv_ext;
    assign reached[j] = interval_ok && (width_ext >= thr);
  end

  always_comb begin
    quot = '0;
    for (int j = 1; j <= MULT_MAX; j++) begin
      if (reached[j]) quot = scale_t'(j);
    end
  end
endmodule

// File: rtl/pfd_fastacq.sv
module pfd_fastacq
  import pfdfa_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_strobe,
  input  logic             lo_strobe,
  input  logic [2:0]       cp_nominal,
  input  logic [DIV_W-1:0] acq_div,
  input  logic             acq_en,
  output logic             pump_up,
  output logic             pump_down,
  output logic [2:0]       pump_scale
);
  logic             pulse_end;
  logic [CNT_W-1:0] interval;
  logic             interval_ok;
  scale_t           quot;
  scale_t           next_scale;

  pfd_edge_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_strobe (ref_strobe),
    .lo_strobe  (lo_strobe),
    .pump_up    (pump_up),
    .pump_down  (pump_down),
    .pulse_end  (pulse_end)
  );

  fa_interval_meter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_intv (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_strobe  (ref_strobe),
    .acq_div     (acq_div),
    .interval    (interval),
    .interval_ok (interval_ok)
  );

  fa_width_quantizer #(.CNT_W(CNT_W)) u_quant (
    .clk         (clk),
    .rst_n       (rst_n),
    .pump_up     (pump_up),
    .pump_down   (pump_down),
    .interval    (interval),
    .interval_ok (interval_ok),
    .quot        (quot)
  );

  // R7 floor of code 1 when enabled, R6 plain nominal otherwise
  assign next_scale = acq_en ? max3(scale_t'(1), cp_nominal, quot) : cp_nominal;

  always_ff @(posedge clk) begin
    if (!rst_n)         pump_scale <= '0;
    else if (pulse_end) pump_scale <= next_scale;
  end
endmodule

// File: rtl/pfd_fastacq_checker.sv
module pfd_fastacq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_strobe,
  input logic       lo_strobe,
  input logic [2:0] cp_nominal,
  input logic       acq_en,
  input logic       pump_up,
  input logic       pump_down,
  input logic [2:0] pump_scale
);
  assert_ref_sets_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_strobe && !(pump_up && pump_down)) |=> pump_up);

  assert_lo_sets_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_strobe && !(pump_up && pump_down)) |=> pump_down);

  assert_overlap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_down) |=> (!pump_up && !pump_down));

  assert_nominal_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_down && !acq_en) |=> (pump_scale == $past(cp_nominal)));

  assert_floor_and_nominal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_down && acq_en) |=> (pump_scale != 3'd0 && pump_scale >= $past(cp_nominal)));

  assert_scale_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_down) |=> $stable(pump_scale));
endmodule

bind pfd_fastacq pfd_fastacq_checker u_chk (.*);

// File: tb/pfd_fastacq_test.sv
module pfd_fastacq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_strobe = 1'b0;
  logic       lo_strobe = 1'b0;
  logic [2:0] cp_nominal = 3'd0;
  logic [7:0] acq_div = 8'd1;
  logic       acq_en = 1'b0;
  logic       pump_up, pump_down;
  logic [2:0] pump_scale;

  int checks = 0;
  int fails = 0;
  int wcount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfd_fastacq uut (
    .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe), .lo_strobe(lo_strobe),
    .cp_nominal(cp_nominal), .acq_div(acq_div), .acq_en(acq_en),
    .pump_up(pump_up), .pump_down(pump_down), .pump_scale(pump_scale)
  );

  always @(negedge clk) if (rst_n && (pump_up ^ pump_down)) wcount++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit en, input int nom, input int dv);
    acq_en = en; cp_nominal = 3'(nom); acq_div = 8'(dv);
    ref_strobe = 0; lo_strobe = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // paired strobes three cycles apart: T = 3 x effective divisor
  task automatic calibrate(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_strobe = 1; lo_strobe = 1;
      @(negedge clk); ref_strobe = 0; lo_strobe = 0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_up(input int g, input int exp, input string req);
    wcount = 0;
    @(negedge clk); ref_strobe = 1;
    @(negedge clk); ref_strobe = 0;
    check("R2 up leads", int'({pump_up, pump_down}), 2);
    repeat (g - 1) @(negedge clk);
    lo_strobe = 1;
    @(negedge clk); lo_strobe = 0;
    check("R3 overlap", int'({pump_up, pump_down}), 3);
    @(negedge clk);
    check("R3 cleared", int'({pump_up, pump_down}), 0);
    check("R4 width", wcount, g);
    check(req, int'(pump_scale), exp);
  endtask

  task automatic pulse_dn(input int g, input int exp, input string req);
    wcount = 0;
    @(negedge clk); lo_strobe = 1;
    @(negedge clk); lo_strobe = 0;
    check("R2 down leads", int'({pump_up, pump_down}), 1);
    repeat (g - 1) @(negedge clk);
    ref_strobe = 1;
    @(negedge clk); ref_strobe = 0;
    check("R3 overlap", int'({pump_up, pump_down}), 3);
    @(negedge clk);
    check("R3 cleared", int'({pump_up, pump_down}), 0);
    check("R4 width", wcount, g);
    check(req, int'(pump_scale), exp);
  endtask

  task automatic t_reset_state();
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 reset outputs", int'({pump_up, pump_down, pump_scale}), 0);
    do_reset(1, 0, 1);
    check("R1 after reset", int'({pump_up, pump_down, pump_scale}), 0);
  endtask

  task automatic t_no_interval_yet();
    do_reset(1, 0, 1);
    pulse_up(10, 1, "R5 no span yet, R7 floor");
    do_reset(1, 0, 1);
    check("R1 reset clears scale", int'(pump_scale), 0);
  endtask

  task automatic t_quotient();
    do_reset(1, 0, 1);
    calibrate(2);
    pulse_up(7, 2, "R7 W=7 T=3");
  endtask

  task automatic t_cap();
    do_reset(1, 0, 1);
    calibrate(2);
    pulse_up(25, 7, "R7 cap at 8x");
  endtask

  task automatic t_nominal_wins_and_hold();
    do_reset(1, 4, 1);
    calibrate(2);
    pulse_up(7, 4, "R7 nominal above quotient");
    cp_nominal = 3'd6;
    acq_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 hold between pulses", int'(pump_scale), 4);
    acq_en = 1'b1;
    pulse_up(7, 6, "R8 update at next pulse end");
  endtask

  task automatic t_down_divisor4();
    do_reset(1, 0, 4);
    calibrate(5);
    pulse_dn(30, 2, "R5 D=4 T=12, R7 W=30");
  endtask

  task automatic t_divisor_zero();
    do_reset(1, 0, 0);
    calibrate(2);
    pulse_up(9, 3, "R5 D=0 acts as 1, R7 W=9");
  endtask

  task automatic t_disabled();
    do_reset(0, 5, 1);
    calibrate(2);
    pulse_up(25, 5, "R6 disabled keeps nominal 5");
    cp_nominal = 3'd0;
    pulse_up(25, 0, "R6 disabled no floor");
  endtask

  task automatic t_simultaneous();
    do_reset(1, 3, 1);
    @(negedge clk); ref_strobe = 1; lo_strobe = 1;
    @(negedge clk); lo_strobe = 0;
    check("R3 simultaneous overlap", int'({pump_up, pump_down}), 3);
    @(negedge clk); ref_strobe = 0;
    check("R3 strobe on clear edge ignored", int'({pump_up, pump_down}), 0);
    check("R7 zero width nominal 3", int'(pump_scale), 3);
    @(negedge clk);
    check("R3 still idle", int'({pump_up, pump_down}), 0);
  endtask

  initial begin
    t_reset_state();
    t_no_interval_yet();
    t_quotient();
    t_cap();
    t_nominal_wins_and_hold();
    t_down_divisor4();
    t_divisor_zero();
    t_disabled();
    t_simultaneous();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule